// File: doc/BRIEF.md
# Masked Priority Interrupt Aggregator

This block merges thirteen level-sensitive interrupt lines from board peripherals into one 4-bit interrupt level for a processor. Each line owns a fixed bit in a 16-bit pending word. The same bit position in a 16-bit enable mask gates that line. The lowest-numbered line that is both pending and enabled wins. Its number is inverted (XOR 15) and sent to the processor, so an output of 0 means that no interrupt is requested.

A small 16-bit register window on a simple synchronous bus holds the enable mask, a general-purpose output port, a fixed version word and a power-down request bit. Software sets the mask through this window. Board logic uses the port and the power-down pulse.

Top module: `irq_level_aggregator`

## Requirements
- R1: After reset the enable mask, output port, pending word, read data, power-down pulse and interrupt level output are all 0.
- R2: Line n (0 to 12) occupies this pending/mask bit: 0→11, 1→9, 2→8, 3→12, 4→10, 5→6, 6→5, 7→4, 8→7, 9→14, 10→13, 11→0, 12→15. Line n takes part only when its own mask bit is set. Mask bits 1, 2 and 3 enable nothing.
- R3: A pending bit is 1 while its line is high and 0 while it is low. The level output reflects a line change at the first rising clock edge after the change.
- R4: Among lines that are pending and enabled, the smallest line number is selected. With no such line the selected number is 15.
- R5: The level output equals the selected number XOR 15. Line 0 gives 15, and no request gives 0.
- R6: Byte offset 0x00 is the enable mask. It is read/write on all 16 bits. A write changes the level output at the same clock edge that stores the new mask.
- R7: Byte offset 0x36 is a 16-bit output port that reads back the value last written. Its value appears on the port output.
- R8: Byte offset 0x30 reads as 0. A write with bit 0 set gives a one-cycle power-down pulse, starting at the clock edge that takes the write. A write with bit 0 clear gives no pulse.
- R9: Byte offset 0x32 reads as 0x0010. Writes to it change nothing.
- R10: Every other offset in the 64-byte window reads as 0, and writes to it change nothing. Odd offsets count as other offsets.
- R11: Read data appears in the cycle after a read select and is 0 in any cycle that did not follow a read select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 13 | Level interrupt lines, index = line number |
| bus_sel | input | 1 | Access select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, one cycle after the read select |
| gp_port | output | 16 | General-purpose output port value |
| pwr_down_req | output | 1 | One-cycle power-down request |
| irq_level | output | 4 | Encoded interrupt level, 0 = none |

## Verification
Every result in this block is due exactly one rising edge after its stimulus: a line change or a mask write moves the level at the next edge, read data follows the select by one edge, and the power-down pulse lasts from that edge to the one after. The bench drives inputs on falling edges. It samples on the next falling edge, half a cycle after the edge that should produce the result. For R3 it also samples once before that edge, to show that the level has not yet moved. The pulse is checked again one cycle later, to show that it has ended.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int NUM_SRC  = 13;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 6;
    localparam int LVL_W    = 4;

    // Fixed placement of each line in the pending/mask word.
    function automatic int src_bit(input int n);
        case (n)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            default: return 15;
        endcase
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] port;
        logic [DATA_W-1:0] rdata;
        logic              pwr;
    } win_state_t;

endpackage

// File: rtl/irq_pending_tracker.sv
module irq_pending_tracker
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int W     = DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lines_i,
    output logic [W-1:0]     pend_d_o,
    output logic [W-1:0]     pend_q_o
);

    logic [W-1:0] pend_d, pend_q;

    always_comb begin
        pend_d = '0;
        for (int n = 0; n < N_SRC; n++) begin
            pend_d[src_bit(n)] = lines_i[n];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_d_o = pend_d;
    assign pend_q_o = pend_q;

    // Bits 1..3 carry no line.
    assert_spare_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[3:1] == 3'b000);

    // Pending bit of line 0 follows the line one edge later.
    assert_line0_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lines_i[0] |=> pend_q[11]);

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_agg_pkg::*;
#(
    parameter int N_SRC = NUM_SRC,
    parameter int W     = DATA_W,
    parameter int LW    = LVL_W
) (
    input  logic [W-1:0]  cand_i,
    output logic [LW-1:0] level_o
);

    localparam logic [LW-1:0] NONE_LVL = {LW{1'b1}};

    logic [N_SRC-1:0] hit;

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_hit
            assign hit[g] = cand_i[src_bit(g)];
        end
    endgenerate

    always_comb begin
        level_o = NONE_LVL;
        for (int n = N_SRC - 1; n >= 0; n--) begin
            if (hit[n]) level_o = LW'(n);
        end
    end

endmodule

// File: rtl/irq_reg_window.sv
module irq_reg_window
    import irq_agg_pkg::*;
#(
    parameter int                W        = DATA_W,
    parameter int                AW       = ADDR_W,
    parameter logic [AW-1:0]     OFS_MASK = 6'h00,
    parameter logic [AW-1:0]     OFS_PWR  = 6'h30,
    parameter logic [AW-1:0]     OFS_VER  = 6'h32,
    parameter logic [AW-1:0]     OFS_PORT = 6'h36,
    parameter logic [W-1:0]      VER_VAL  = 16'h0010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  rdata_o,
    output logic [W-1:0]  mask_d_o,
    output logic [W-1:0]  mask_q_o,
    output logic [W-1:0]  port_o,
    output logic          pwr_o
);

    win_state_t st_d, st_q;
    logic wr, rd;

    assign wr = sel_i &&  we_i;
    assign rd = sel_i && !we_i;

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.pwr   = 1'b0;
        if (wr) begin
            unique case (addr_i)
                OFS_MASK: st_d.mask = wdata_i;
                OFS_PORT: st_d.port = wdata_i;
                OFS_PWR:  st_d.pwr  = wdata_i[0];
                default:  ;
            endcase
        end
        if (rd) begin
            unique case (addr_i)
                OFS_MASK: st_d.rdata = st_q.mask;
                OFS_PORT: st_d.rdata = st_q.port;
                OFS_VER:  st_d.rdata = VER_VAL;
                default:  st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o  = st_q.rdata;
    assign mask_d_o = st_d.mask;
    assign mask_q_o = st_q.mask;
    assign port_o   = st_q.port;
    assign pwr_o    = st_q.pwr;

    assert_pwr_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_o |=> !pwr_o);

    assert_ver_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr_i == OFS_VER) |=> rdata_o == VER_VAL);

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> rdata_o == '0);

    assert_mask_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr_i == OFS_MASK) |=> mask_q_o == $past(wdata_i));

endmodule

// File: rtl/irq_level_aggregator.sv
module irq_level_aggregator
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_lines,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [DATA_W-1:0]  gp_port,
    output logic               pwr_down_req,
    output logic [LVL_W-1:0]   irq_level
);

    localparam logic [LVL_W-1:0] INV = {LVL_W{1'b1}};

    logic [DATA_W-1:0] pend_d, pend_q, mask_d, mask_q;
    logic [LVL_W-1:0]  sel_lvl;
    logic [LVL_W-1:0]  out_d, out_q;

    irq_pending_tracker u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_i  (irq_lines),
        .pend_d_o (pend_d),
        .pend_q_o (pend_q)
    );

    irq_reg_window u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (bus_sel),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .rdata_o  (bus_rdata),
        .mask_d_o (mask_d),
        .mask_q_o (mask_q),
        .port_o   (gp_port),
        .pwr_o    (pwr_down_req)
    );

    // Selection uses next-state pending and mask so the level moves on
    // the same edge that stores them.
    irq_prio_select u_sel (
        .cand_i  (pend_d & mask_d),
        .level_o (sel_lvl)
    );

    always_comb begin
        out_d = sel_lvl ^ INV;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_level = out_q;

    assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & mask_q) == '0) |-> irq_level == '0);

    assert_top_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[11] && mask_q[11]) |-> irq_level == 4'hF);

    assert_spare_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & mask_q & 16'hFFF1) == '0) |-> irq_level == '0);

endmodule

// File: tb/irq_level_aggregator_bench.sv
module irq_level_aggregator_bench;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [12:0] irq_lines = '0;
    logic        bus_sel = 0, bus_we = 0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, gp_port;
    logic        pwr_down_req;
    logic [3:0]  irq_level;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_level_aggregator u_irq_level_aggregator (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gp_port(gp_port),
        .pwr_down_req(pwr_down_req), .irq_level(irq_level)
    );

    function automatic int exp_bit(input int n);
        int tbl [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return tbl[n];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [15:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [15:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic set_lines(input logic [12:0] v);
        irq_lines = v;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] r;
        check("R1 level", {12'h0, irq_level}, 16'h0);
        check("R1 port", gp_port, 16'h0);
        check("R1 pwr", {15'h0, pwr_down_req}, 16'h0);
        check("R1 rdata", bus_rdata, 16'h0);
        bus_read(6'h00, r);
        check("R1 mask", r, 16'h0);
    endtask

    task automatic t_mapping;
        for (int n = 0; n < 13; n++) begin
            bus_write(6'h00, 16'(1) << exp_bit(n));
            set_lines(13'(1) << n);
            check("R2 own bit", {12'h0, irq_level}, 16'(n ^ 15));
            bus_write(6'h00, ~(16'(1) << exp_bit(n)));
            check("R2 other bits", {12'h0, irq_level}, 16'h0);
        end
        bus_write(6'h00, 16'h000E);
        set_lines(13'h1FFF);
        check("R2 spare bits", {12'h0, irq_level}, 16'h0);
        set_lines('0);
    endtask

    task automatic t_level;
        bus_write(6'h00, 16'hFFFF);
        irq_lines = 13'(1) << 7;
        #1;
        check("R3 before edge", {12'h0, irq_level}, 16'h0);
        @(negedge clk);
        check("R3 after edge", {12'h0, irq_level}, 16'(7 ^ 15));
        set_lines('0);
        check("R3 line low", {12'h0, irq_level}, 16'h0);
    endtask

    task automatic t_priority;
        bus_write(6'h00, 16'hFFFF);
        set_lines(13'h1FFF);
        check("R5 line0 gives 15", {12'h0, irq_level}, 16'hF);
        set_lines((13'(1) << 12) | (13'(1) << 5));
        check("R4 smallest wins", {12'h0, irq_level}, 16'(5 ^ 15));
        set_lines(13'(1) << 12);
        check("R4 line12", {12'h0, irq_level}, 16'(12 ^ 15));
        set_lines(13'h0);
        check("R4 none", {12'h0, irq_level}, 16'h0);
    endtask

    task automatic t_mask;
        logic [15:0] r;
        set_lines((13'(1) << 12) | (13'(1) << 5));
        bus_write(6'h00, 16'hFFFF & ~(16'(1) << 6));
        check("R6 mask write moves level", {12'h0, irq_level}, 16'(12 ^ 15));
        bus_write(6'h00, 16'hA5C3);
        bus_read(6'h00, r);
        check("R6 mask readback", r, 16'hA5C3);
        set_lines('0);
    endtask

    task automatic t_port;
        logic [15:0] r;
        bus_write(6'h36, 16'h1234);
        check("R7 port out", gp_port, 16'h1234);
        bus_read(6'h36, r);
        check("R7 port read", r, 16'h1234);
    endtask

    task automatic t_power;
        logic [15:0] r;
        bus_write(6'h30, 16'h0001);
        check("R8 pulse", {15'h0, pwr_down_req}, 16'h1);
        @(negedge clk);
        check("R8 pulse ends", {15'h0, pwr_down_req}, 16'h0);
        bus_write(6'h30, 16'hFFFE);
        check("R8 bit0 clear", {15'h0, pwr_down_req}, 16'h0);
        bus_read(6'h30, r);
        check("R8 reads 0", r, 16'h0);
    endtask

    task automatic t_version;
        logic [15:0] r;
        bus_write(6'h32, 16'hBEEF);
        bus_read(6'h32, r);
        check("R9 version", r, 16'h0010);
    endtask

    task automatic t_other;
        logic [15:0] r;
        bus_write(6'h00, 16'h00FF);
        bus_write(6'h36, 16'h0F0F);
        bus_write(6'h02, 16'hFFFF);
        bus_write(6'h01, 16'hFFFF);
        bus_write(6'h37, 16'hFFFF);
        bus_read(6'h02, r);
        check("R10 read other", r, 16'h0);
        bus_read(6'h3E, r);
        check("R10 read high", r, 16'h0);
        bus_read(6'h31, r);
        check("R10 read odd", r, 16'h0);
        bus_read(6'h00, r);
        check("R10 mask untouched", r, 16'h00FF);
        check("R10 port untouched", gp_port, 16'h0F0F);
    endtask

    task automatic t_rdata;
        logic [15:0] r;
        bus_read(6'h36, r);
        check("R11 read", r, 16'h0F0F);
        @(negedge clk);
        check("R11 idle zero", bus_rdata, 16'h0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mapping();
        t_level();
        t_priority();
        t_mask();
        t_port();
        t_power();
        t_version();
        t_other();
        t_rdata();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule